// File: doc/BRIEF.md
# Gated Multi-Source Clock Frequency Meter

This block reports how fast one of many on-chip clocks is running. A bank of up to 128 candidate clocks feeds a selector. The chosen clock is brought into the system clock domain, and its rising edges are counted over a gate window. The window length is programmed in whole microseconds. A free-running prescaler divides the system clock down to a one-cycle pulse every microsecond, and that pulse paces the gate.

Software drives the block through four 32-bit word registers. It writes the gate length (stored as the length minus one) and the source index, then sets enable and run together in the control word. It then polls the busy flag until busy clears, drops enable, and reads the edge count. The frequency in Hz is the count times one million divided by the gate length in microseconds. The count saturates at all ones, and software treats that value as an overflow. In continuous mode, windows follow one another for as long as enable stays set, and the result is refreshed at the end of each window.

Top module: `clkmeter_top`

## Requirements
- R1: After reset, the control word, the result word and both auxiliary words read as zero, so busy is low.
- R2: The control word at byte offset 0x4 reads back as follows: the gate length minus one in [15:0], enable in bit 16, continuous in bit 17, interrupt-enable in bit 18 and the source index in [26:20]. Bit 19 (run) always reads 0, bits [30:27] read 0, and bit 31 is busy.
- R3: The words at byte offsets 0x0 and 0x8 are plain 32-bit storage and return the last value written to them.
- R4: A control write that sets both bit 16 and bit 19 while the block is idle raises busy from the next cycle on. The gate opens on the next microsecond pulse and lasts N+1 microseconds, where N is the stored gate field. Busy then clears. A run written without enable starts nothing. Microsecond pulses are exactly TICKS_PER_US cycles apart.
- R5: The result word at offset 0xC holds, in bits [CNT_W-1:0], the number of rising edges of the selected source seen during the gate, within one edge. All higher bits read 0.
- R6: The edge count saturates at 2^CNT_W-1 (0xFFFF by default) and holds that value to the end of the window.
- R7: While busy is set, a further run has no effect, and writes to the gate and source fields are ignored. The window in progress keeps its length and its source.
- R8: The result changes only at the end of a window. It stays stable after enable is cleared and while the block is idle.
- R9: With continuous mode and enable set, a new window starts at the end of each window without busy dropping, and the result updates at every window end. When enable is cleared, busy falls at the end of the current window.
- R10: A source held at a constant level gives a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk_i | input | NUM_SRC | Candidate clocks to be measured |
| bus_we_i | input | 1 | Register write strobe, sampled on the rising clock edge |
| bus_addr_i | input | 4 | Byte address of the register (0x0, 0x4, 0x8, 0xC) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |

## Verification
The block is tried with three free-running sources whose periods do not divide the system clock period (40 ns, 70 ns and 24 ns), and with one source tied low. Several gate lengths are used with them. Checking the counts against different periods and gate lengths separates a correct window length from an off-by-one in the minus-one encoding, and separates a correct source selection from a wrong one. The fast source with a long gate drives the counter into saturation, while the silent source exposes any spurious edge from the synchronizer or from a switch of source. A control write in the middle of a window, and a continuous run that is stopped by clearing enable, tell the write-protection and restart paths apart from single-shot behaviour.

// File: rtl/clkmeter_pkg.sv
package clkmeter_pkg;

    localparam logic [3:0] ADDR_AUX0 = 4'h0;
    localparam logic [3:0] ADDR_CTRL = 4'h4;
    localparam logic [3:0] ADDR_AUX1 = 4'h8;
    localparam logic [3:0] ADDR_RES  = 4'hC;

    localparam int BIT_EN     = 16;
    localparam int BIT_CONT   = 17;
    localparam int BIT_IRQ    = 18;
    localparam int BIT_RUN    = 19;
    localparam int SRC_LSB    = 20;
    localparam int BIT_BUSY   = 31;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_GATE = 2'd2
    } meas_state_e;

endpackage

// File: rtl/clkmeter_us_tick.sv
module clkmeter_us_tick #(
    parameter int TICKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_US - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (TICKS_PER_US > 1) begin : g_spacing
            // R4: pulses are single cycles
            assert_tick_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/clkmeter_src_sync.sv
module clkmeter_src_sync #(
    parameter int NUM_SRC = 128,
    parameter int SEL_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  picked;

    always_comb begin
        picked = (int'(sel_i) < NUM_SRC) ? src_i[sel_i] : 1'b0;
        s_d.meta = picked;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
        rise_o   = s_q.sync & ~s_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/clkmeter_edge_ctr.sv
module clkmeter_edge_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        if (clear_i)
            count_d = {{(CNT_W-1){1'b0}}, inc_i};
        else if (inc_i && count_q != FULL)
            count_d = count_q + 1'b1;
        else
            count_d = count_q;
        count_o = count_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R6: a full counter stays full until cleared
    assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && count_q == FULL) |=> (count_q == FULL));

endmodule

// File: rtl/clkmeter_top.sv
module clkmeter_top
    import clkmeter_pkg::*;
#(
    parameter int NUM_SRC      = 128,
    parameter int TICKS_PER_US = 100,
    parameter int CNT_W        = 16,
    parameter int GATE_W       = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic               bus_we_i,
    input  logic [3:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o
);
    localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    typedef struct packed {
        logic [31:0]       aux0;
        logic [31:0]       aux1;
        logic [GATE_W-1:0] gate_m1;
        logic              en;
        logic              cont;
        logic              irq_en;
        logic [SEL_W-1:0]  src_sel;
        meas_state_e       st;
        logic [GATE_W-1:0] gate_cnt;
        logic [CNT_W-1:0]  result;
    } meter_t;

    meter_t d, q;

    logic             tick;
    logic             src_rise;
    logic             ctr_clear;
    logic             ctr_inc;
    logic [CNT_W-1:0] edge_cnt;
    logic             busy;
    logic             ctrl_wr;
    logic             start;
    logic             win_done;
    logic [31:0]      ctrl_rd;
    logic             unused_wbits;

    clkmeter_us_tick #(.TICKS_PER_US(TICKS_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    clkmeter_src_sync #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_clk_i),
        .sel_i  (q.src_sel),
        .rise_o (src_rise)
    );

    clkmeter_edge_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (ctr_clear),
        .inc_i   (ctr_inc),
        .count_o (edge_cnt)
    );

    assign unused_wbits = ^bus_wdata_i;

    always_comb begin
        d         = q;
        ctr_clear = 1'b0;
        win_done  = 1'b0;
        busy      = (q.st != ST_IDLE);
        ctrl_wr   = bus_we_i && (bus_addr_i == ADDR_CTRL);
        start     = ctrl_wr && !busy && bus_wdata_i[BIT_EN] && bus_wdata_i[BIT_RUN];
        ctr_inc   = src_rise && (q.st == ST_GATE);

        if (bus_we_i) begin
            case (bus_addr_i)
                ADDR_AUX0: d.aux0 = bus_wdata_i;
                ADDR_AUX1: d.aux1 = bus_wdata_i;
                ADDR_CTRL: begin
                    d.en     = bus_wdata_i[BIT_EN];
                    d.cont   = bus_wdata_i[BIT_CONT];
                    d.irq_en = bus_wdata_i[BIT_IRQ];
                    if (!busy) begin
                        d.gate_m1 = bus_wdata_i[GATE_W-1:0];
                        d.src_sel = bus_wdata_i[SRC_LSB +: SEL_W];
                    end
                end
                default: ;
            endcase
        end

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st      = ST_ARM;
                    ctr_clear = 1'b1;
                end
            end
            ST_ARM: begin
                if (tick) begin
                    d.st       = ST_GATE;
                    d.gate_cnt = '0;
                    ctr_clear  = 1'b1;
                end
            end
            ST_GATE: begin
                if (tick) begin
                    if (q.gate_cnt == q.gate_m1) begin
                        win_done   = 1'b1;
                        d.result   = edge_cnt;
                        d.gate_cnt = '0;
                        if (q.cont && d.en) begin
                            ctr_clear = 1'b1;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.gate_cnt = q.gate_cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        ctrl_rd                       = '0;
        ctrl_rd[GATE_W-1:0]           = q.gate_m1;
        ctrl_rd[BIT_EN]               = q.en;
        ctrl_rd[BIT_CONT]             = q.cont;
        ctrl_rd[BIT_IRQ]              = q.irq_en;
        ctrl_rd[SRC_LSB +: SEL_W]     = q.src_sel;
        ctrl_rd[BIT_BUSY]             = busy;

        case (bus_addr_i)
            ADDR_AUX0: bus_rdata_o = q.aux0;
            ADDR_CTRL: bus_rdata_o = ctrl_rd;
            ADDR_AUX1: bus_rdata_o = q.aux1;
            ADDR_RES:  bus_rdata_o = {{(32-CNT_W){1'b0}}, q.result};
            default:   bus_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // R4: an accepted start makes the block busy in the next cycle
    assert_busy_after_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.st == ST_ARM));

    // R4: the gate counter never passes the programmed length
    assert_gate_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_GATE) |-> (q.gate_cnt <= q.gate_m1));

    // R7: window settings are frozen while busy
    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(q.gate_m1) && $stable(q.src_sel)));

    // R8: the result moves only at a window end
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> $stable(q.result));

    // R9: a continuous restart keeps the block busy
    assert_cont_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && q.cont && d.en) |=> (q.st == ST_GATE));

endmodule

// File: tb/clkmeter_top_bench.sv
module clkmeter_top_bench;

    localparam int NSRC  = 128;
    localparam int TUS   = 10;
    localparam int CW    = 8;
    localparam int CYCNS = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src;
    logic            bus_we = 1'b0;
    logic [3:0]      bus_addr = 4'h4;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;

    logic s5 = 1'b0, s77 = 1'b0, s127 = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        string tag;
        int    lo;
        int    hi;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    initial begin #3; forever #20 s5 = ~s5; end
    initial begin #7; forever #35 s77 = ~s77; end
    initial begin #4; forever #12 s127 = ~s127; end

    always_comb begin
        src      = '0;
        src[5]   = s5;
        src[77]  = s77;
        src[127] = s127;
    end

    clkmeter_top #(
        .NUM_SRC(NSRC), .TICKS_PER_US(TUS), .CNT_W(CW), .GATE_W(16)
    ) u_clkmeter_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_clk_i   (src),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata)
    );

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_addr  = 4'h4;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int srcidx, input int n, input bit en,
                                              input bit cont, input bit run);
        return (32'(srcidx) << 20) | (32'(run) << 19) | (32'(cont) << 17) |
               (32'(en) << 16) | 32'(n);
    endfunction

    // scoreboard: driver side
    task automatic push_exp(input string tag, input int lo, input int hi);
        exp_t e;
        e.tag = tag; e.lo = lo; e.hi = hi;
        exp_q.push_back(e);
    endtask

    // scoreboard: monitor side
    task automatic collect_result();
        logic [31:0] v;
        exp_t e;
        rd(4'hC, v);
        if (exp_q.size() == 0) begin
            check(1'b0, "scoreboard empty", longint'(v), 0);
        end else begin
            e = exp_q.pop_front();
            check((v >= 32'(e.lo)) && (v <= 32'(e.hi)), e.tag, longint'(v), longint'(e.lo));
        end
    endtask

    task automatic wait_idle(output int len);
        logic [31:0] v;
        len = 0;
        do begin
            rd(4'h4, v);
            if (v[31]) len++;
        end while (v[31] && len < 5000);
    endtask

    task automatic single(input int srcidx, input int n, input int period_ns, input bit saturating,
                          input string tag);
        int win_ns, base, len;
        win_ns = (n + 1) * TUS * CYCNS;
        if (saturating) begin
            push_exp(tag, (1 << CW) - 1, (1 << CW) - 1);
        end else if (period_ns == 0) begin
            push_exp(tag, 0, 0);
        end else begin
            base = win_ns / period_ns;
            push_exp(tag, (base > 0) ? base - 1 : 0, base + 1);
        end
        wr(4'h4, ctrl_word(srcidx, n, 1'b1, 1'b0, 1'b1));
        wait_idle(len);
        check(len >= (n + 1) * TUS && len <= (n + 2) * TUS, "R4 busy length",
              longint'(len), longint'((n + 1) * TUS));
        collect_result();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v, r1, r2;
        int len;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(4'h4, v); check(v == 0, "R1 control after reset", longint'(v), 0);
        rd(4'hC, v); check(v == 0, "R1 result after reset", longint'(v), 0);
        rd(4'h0, v); check(v == 0, "R1 aux0 after reset", longint'(v), 0);

        // R3: auxiliary storage
        wr(4'h0, 32'hA5A5_1234);
        wr(4'h8, 32'h0F0F_F0F0);
        rd(4'h0, v); check(v == 32'hA5A5_1234, "R3 aux0 readback", longint'(v), 32'hA5A5_1234);
        rd(4'h8, v); check(v == 32'h0F0F_F0F0, "R3 aux1 readback", longint'(v), 32'h0F0F_F0F0);

        // R2 / R4: field readback, run without enable starts nothing
        wr(4'h4, 32'h055E_1234);
        repeat (3) @(negedge clk);
        rd(4'h4, v); check(v == 32'h0556_1234, "R2 control fields, R4 no start without enable",
                           longint'(v), 32'h0556_1234);

        // R5 / R4: 40 ns source, 8 us
        single(5, 7, 40, 1'b0, "R5 count src5 8us");

        // R8: clear enable, result stays
        rd(4'hC, r1);
        wr(4'h4, ctrl_word(5, 7, 1'b0, 1'b0, 1'b0));
        repeat (30) @(negedge clk);
        rd(4'hC, r2); check(r1 == r2, "R8 result after enable drop", longint'(r2), longint'(r1));

        // R5: 70 ns source, 10 us
        single(77, 9, 70, 1'b0, "R5 count src77 10us");

        // R10: silent source
        single(0, 4, 0, 1'b0, "R10 constant source");

        // R7: writes while busy
        push_exp("R7 count unaffected by write during window", 49, 51);
        wr(4'h4, ctrl_word(5, 19, 1'b1, 1'b0, 1'b1));
        repeat (20) @(negedge clk);
        wr(4'h4, ctrl_word(77, 3, 1'b1, 1'b0, 1'b1));
        rd(4'h4, v);
        check(v[15:0] == 16'd19, "R7 gate field kept", longint'(v[15:0]), 19);
        check(v[26:20] == 7'd5, "R7 source field kept", longint'(v[26:20]), 5);
        check(v[31] == 1'b1, "R7 still busy after write", longint'(v[31]), 1);
        repeat (100) @(negedge clk);
        rd(4'h4, v); check(v[31] == 1'b1, "R7 window not shortened", longint'(v[31]), 1);
        wait_idle(len);
        collect_result();

        // R9: continuous mode, 4 us windows, 40 ns source
        wr(4'h4, ctrl_word(0, 4, 1'b1, 1'b0, 1'b1));
        wait_idle(len);
        collect_result_zero();
        wr(4'h4, ctrl_word(5, 3, 1'b1, 1'b1, 1'b1));
        repeat (60) @(negedge clk);
        rd(4'h4, v); check(v[31] == 1'b1, "R9 busy across restart", longint'(v[31]), 1);
        push_exp("R9 first continuous window", 9, 11);
        collect_result();
        repeat (45) @(negedge clk);
        rd(4'h4, v); check(v[31] == 1'b1, "R9 still busy in later window", longint'(v[31]), 1);
        push_exp("R9 later continuous window", 9, 11);
        collect_result();
        wr(4'h4, ctrl_word(5, 3, 1'b0, 1'b1, 1'b0));
        wait_idle(len);
        check(len <= 4 * TUS + 2, "R9 stop at window end", longint'(len), 4 * TUS);
        rd(4'hC, r1);
        repeat (100) @(negedge clk);
        rd(4'hC, r2); check(r1 == r2, "R8 result stable while idle", longint'(r2), longint'(r1));
        rd(4'h4, v); check(v[31] == 1'b0, "R9 no restart after enable cleared", longint'(v[31]), 0);

        // R6: saturation with 24 ns source over 80 us
        single(127, 79, 24, 1'b1, "R6 saturated count");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic collect_result_zero();
        push_exp("R10 silent source before continuous run", 0, 0);
        collect_result();
    endtask

endmodule